// File: doc/BRIEF.md
# Row copy-on-write version logger

This block sits in a memory controller between the last-level-cache eviction path and the DRAM command queue. Each eviction arrives as a write to one main-region row, tagged with the current epoch number. When that row has not yet been saved in this epoch, the block holds the write. It then issues a row-copy command that saves the row's old contents into the next unused logging-region row and waits for the copy acknowledge. Next it rewrites three pointer tags so that the new undo entry joins the row's version chain. Only after that does it forward the write.

The block keeps the pointer tags for every row of both regions and a per-row record of the epoch in which the row was last saved. It also keeps one row-ID list for each recent epoch. A background migration engine reads these lists through a read port, which returns the list's epoch, its length and any entry. Rows of both regions share one pointer space: main rows take the low addresses, and logging rows follow them. Logging rows are never freed here, so once all of them are used the block reports that it is full. From then on it holds any write that would need a new undo entry.

Top module: `row_cow_logger`

## Requirements
- R1: While reset is applied and after it is released, with no write offered, wr_ready, fwd_valid, copy_valid, tag_we and log_full are all low, and every list reads back with count 0.
- R2: Pointer addresses 0 to MAIN_ROWS-1 name main rows, and MAIN_ROWS to MAIN_ROWS+LOG_ROWS-1 name logging rows. Logging rows are handed out in increasing order, starting at address MAIN_ROWS.
- R3: If the offered row was already saved in the offered epoch, the write is accepted and forwarded in the same cycle: wr_ready=1, fwd_valid=1, fwd_row=wr_row. No copy or tag write takes place.
- R4: A write to a row not yet saved in the offered epoch is not forwarded at first. From the next cycle, copy_valid=1 with copy_src equal to the row and copy_dst equal to the next free logging row. These values are held unchanged until the cycle in which copy_done is seen high.
- R5: In the three cycles after the copy acknowledge, tag writes occur in a fixed order. First the main row's tag is set to the new entry. Then the new entry's tag is set to the main row. Then, only if the row already had an older entry, that older entry's tag is set to the new entry. With no older entry, the third write is skipped.
- R6: In the cycle after the last tag write, the held write is forwarded with wr_ready=1. The row ID is appended to the list numbered epoch mod NUM_LISTS. If that list last held a different epoch, it restarts at slot 0; otherwise the entry goes to the next slot.
- R7: After LOG_ROWS entries have been made, log_full=1. A write that would need a new entry is then held with wr_ready=0 and no copy. A write to a row already saved in the current epoch is still forwarded at once.
- R8: Offering an epoch other than the one in which a row was last saved makes the row unsaved again, so the next write to it starts a new copy.
- R9: The epoch is taken when the write is first offered. A change on wr_epoch while the write is held does not change the list that receives the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Eviction write offered; held until wr_ready |
| wr_row | input | MAIN_AW | Main-region row of the write |
| wr_epoch | input | EPOCH_W | Current epoch number |
| wr_ready | output | 1 | Write accepted this cycle |
| fwd_valid | output | 1 | Forwarded data write to DRAM |
| fwd_row | output | MAIN_AW | Row of the forwarded write |
| copy_valid | output | 1 | Row-copy command pending |
| copy_src | output | PTR_W | Copy source row (main region) |
| copy_dst | output | PTR_W | Copy destination row (logging region) |
| copy_done | input | 1 | Copy acknowledge |
| tag_we | output | 1 | Tag memory write strobe |
| tag_addr | output | PTR_W | Row whose tag is written |
| tag_data | output | PTR_W | New pointer value |
| log_full | output | 1 | No free logging row remains |
| lst_rd_sel | input | SEL_W | List to read |
| lst_rd_slot | input | LOG_AW | Entry index to read |
| lst_rd_epoch | output | EPOCH_W | Epoch held by the selected list |
| lst_rd_count | output | CNT_W | Number of entries in the selected list |
| lst_rd_row | output | MAIN_AW | Row ID at the selected slot |

## Verification
The assertions check, on every cycle, the rules that involve only a few signals. A copy command keeps its operands until it is acknowledged. Copy destinations always fall in the logging region. A tag written for a main row always points into the logging region. No copy is issued while the log is full. Forwarding after a copy always comes straight after a tag write. Other behaviour depends on history, which only the bench's scenarios can show. These cases include the choice between hit and miss across epochs, whether the third tag write is made or skipped, the pointer to the older entry, the order in which list slots restart, the epoch held at the start of a write, and the difference between a held miss and a forwarded hit once the log is full.

// File: rtl/rcl_pkg.sv
package rcl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COPY,
    ST_TAG_MAIN,
    ST_TAG_NEW,
    ST_TAG_PREV,
    ST_DONE
  } rcl_state_e;
endpackage

// File: rtl/rcl_epoch_mark.sv
module rcl_epoch_mark #(
  parameter int ROWS    = 16,
  parameter int EPOCH_W = 4,
  localparam int AW     = $clog2(ROWS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      rd_row,
  input  logic [EPOCH_W-1:0] rd_epoch,
  output logic               rd_hit,
  output logic               rd_ever,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_row,
  input  logic [EPOCH_W-1:0] wr_epoch
);
  logic [EPOCH_W-1:0] mark_q [ROWS];
  logic [ROWS-1:0]    seen_q;

  assign rd_ever = seen_q[rd_row];
  assign rd_hit  = seen_q[rd_row] && (mark_q[rd_row] == rd_epoch);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      for (int i = 0; i < ROWS; i++) mark_q[i] <= '0;
    end else if (wr_en) begin
      seen_q[wr_row] <= 1'b1;
      mark_q[wr_row] <= wr_epoch;
    end
  end
endmodule

// File: rtl/rcl_log_alloc.sv
module rcl_log_alloc #(
  parameter int MAIN_ROWS = 16,
  parameter int LOG_ROWS  = 8,
  localparam int PTR_W    = $clog2(MAIN_ROWS + LOG_ROWS),
  localparam int CNT_W    = $clog2(LOG_ROWS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [PTR_W-1:0] next_ptr,
  output logic             full
);
  logic [CNT_W-1:0] used_q, used_d;

  assign full     = (used_q == CNT_W'(LOG_ROWS));
  assign next_ptr = PTR_W'(MAIN_ROWS) + PTR_W'(used_q);

  always_comb begin
    used_d = used_q;
    if (adv && !full) used_d = used_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) used_q <= '0;
    else        used_q <= used_d;
  end
endmodule

// File: rtl/rcl_tag_store.sv
module rcl_tag_store #(
  parameter int ROWS  = 24,
  parameter int PTR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  logic [PTR_W-1:0] wdata,
  input  logic [PTR_W-1:0] raddr,
  output logic [PTR_W-1:0] rdata
);
  logic [PTR_W-1:0] tag_q [ROWS];

  assign rdata = tag_q[raddr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) tag_q[i] <= '0;
    end else if (we) begin
      tag_q[waddr] <= wdata;
    end
  end
endmodule

// File: rtl/rcl_epoch_lists.sv
module rcl_epoch_lists #(
  parameter int NUM_LISTS = 4,
  parameter int LOG_ROWS  = 8,
  parameter int EPOCH_W   = 4,
  parameter int ROW_W     = 4,
  localparam int SEL_W    = $clog2(NUM_LISTS),
  localparam int SLOT_W   = $clog2(LOG_ROWS),
  localparam int CNT_W    = $clog2(LOG_ROWS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [EPOCH_W-1:0] push_epoch,
  input  logic [ROW_W-1:0]   push_row,
  input  logic [SEL_W-1:0]   rd_sel,
  input  logic [SLOT_W-1:0]  rd_slot,
  output logic [EPOCH_W-1:0] rd_epoch,
  output logic [CNT_W-1:0]   rd_count,
  output logic [ROW_W-1:0]   rd_row
);
  logic [ROW_W-1:0]   ent_q [NUM_LISTS][LOG_ROWS];
  logic [CNT_W-1:0]   cnt_q [NUM_LISTS];
  logic [EPOCH_W-1:0] ep_q  [NUM_LISTS];
  logic [NUM_LISTS-1:0] live_q;

  logic [SEL_W-1:0] psel;
  logic             same_ep;
  logic [CNT_W-1:0] slot;

  assign psel    = push_epoch[SEL_W-1:0];
  assign same_ep = live_q[psel] && (ep_q[psel] == push_epoch);
  assign slot    = same_ep ? cnt_q[psel] : '0;

  assign rd_epoch = ep_q[rd_sel];
  assign rd_count = live_q[rd_sel] ? cnt_q[rd_sel] : '0;
  assign rd_row   = ent_q[rd_sel][rd_slot];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      for (int l = 0; l < NUM_LISTS; l++) begin
        cnt_q[l] <= '0;
        ep_q[l]  <= '0;
        for (int s = 0; s < LOG_ROWS; s++) ent_q[l][s] <= '0;
      end
    end else if (push) begin
      live_q[psel]                    <= 1'b1;
      ep_q[psel]                      <= push_epoch;
      cnt_q[psel]                     <= slot + 1'b1;
      ent_q[psel][SLOT_W'(slot)]      <= push_row;
    end
  end
endmodule

// File: rtl/row_cow_logger.sv
module row_cow_logger
  import rcl_pkg::*;
#(
  parameter int MAIN_ROWS = 16,
  parameter int LOG_ROWS  = 8,
  parameter int EPOCH_W   = 4,
  parameter int NUM_LISTS = 4,
  localparam int MAIN_AW  = $clog2(MAIN_ROWS),
  localparam int PTR_W    = $clog2(MAIN_ROWS + LOG_ROWS),
  localparam int SEL_W    = $clog2(NUM_LISTS),
  localparam int LOG_AW   = $clog2(LOG_ROWS),
  localparam int CNT_W    = $clog2(LOG_ROWS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  input  logic [MAIN_AW-1:0] wr_row,
  input  logic [EPOCH_W-1:0] wr_epoch,
  output logic               wr_ready,
  output logic               fwd_valid,
  output logic [MAIN_AW-1:0] fwd_row,
  output logic               copy_valid,
  output logic [PTR_W-1:0]   copy_src,
  output logic [PTR_W-1:0]   copy_dst,
  input  logic               copy_done,
  output logic               tag_we,
  output logic [PTR_W-1:0]   tag_addr,
  output logic [PTR_W-1:0]   tag_data,
  output logic               log_full,
  input  logic [SEL_W-1:0]   lst_rd_sel,
  input  logic [LOG_AW-1:0]  lst_rd_slot,
  output logic [EPOCH_W-1:0] lst_rd_epoch,
  output logic [CNT_W-1:0]   lst_rd_count,
  output logic [MAIN_AW-1:0] lst_rd_row
);
  localparam logic [PTR_W-1:0] LOG_BASE = PTR_W'(MAIN_ROWS);

  rcl_state_e         state_q, state_d;
  logic [MAIN_AW-1:0] row_q;
  logic [EPOCH_W-1:0] ep_q;
  logic [PTR_W-1:0]   dst_q, prev_q;
  logic               has_prev_q;

  logic               hit, ever, load, commit;
  logic [PTR_W-1:0]   alloc_ptr, main_tag;
  logic [PTR_W-1:0]   row_ptr;

  assign row_ptr = PTR_W'(row_q);

  rcl_epoch_mark #(.ROWS(MAIN_ROWS), .EPOCH_W(EPOCH_W)) u_mark (
    .clk(clk), .rst_n(rst_n),
    .rd_row(wr_row), .rd_epoch(wr_epoch), .rd_hit(hit), .rd_ever(ever),
    .wr_en(commit), .wr_row(row_q), .wr_epoch(ep_q)
  );

  rcl_log_alloc #(.MAIN_ROWS(MAIN_ROWS), .LOG_ROWS(LOG_ROWS)) u_alloc (
    .clk(clk), .rst_n(rst_n), .adv(commit), .next_ptr(alloc_ptr), .full(log_full)
  );

  rcl_tag_store #(.ROWS(MAIN_ROWS + LOG_ROWS), .PTR_W(PTR_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .we(tag_we), .waddr(tag_addr), .wdata(tag_data),
    .raddr(PTR_W'(wr_row)), .rdata(main_tag)
  );

  rcl_epoch_lists #(.NUM_LISTS(NUM_LISTS), .LOG_ROWS(LOG_ROWS),
                    .EPOCH_W(EPOCH_W), .ROW_W(MAIN_AW)) u_lists (
    .clk(clk), .rst_n(rst_n),
    .push(commit), .push_epoch(ep_q), .push_row(row_q),
    .rd_sel(lst_rd_sel), .rd_slot(lst_rd_slot),
    .rd_epoch(lst_rd_epoch), .rd_count(lst_rd_count), .rd_row(lst_rd_row)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (wr_valid && !hit && !log_full) begin
        load    = 1'b1;
        state_d = ST_COPY;
      end
      ST_COPY:     if (copy_done) state_d = ST_TAG_MAIN;
      ST_TAG_MAIN: state_d = ST_TAG_NEW;
      ST_TAG_NEW:  state_d = has_prev_q ? ST_TAG_PREV : ST_DONE;
      ST_TAG_PREV: state_d = ST_DONE;
      ST_DONE:     state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  // Output decode
  always_comb begin
    tag_we   = 1'b0;
    tag_addr = '0;
    tag_data = '0;
    unique case (state_q)
      ST_TAG_MAIN: begin tag_we = 1'b1; tag_addr = row_ptr; tag_data = dst_q;   end
      ST_TAG_NEW:  begin tag_we = 1'b1; tag_addr = dst_q;   tag_data = row_ptr; end
      ST_TAG_PREV: begin tag_we = 1'b1; tag_addr = prev_q;  tag_data = dst_q;   end
      default: ;
    endcase
  end

  assign commit     = (state_q == ST_DONE);
  assign wr_ready   = (state_q == ST_IDLE && wr_valid && hit) || commit;
  assign fwd_valid  = wr_ready;
  assign fwd_row    = commit ? row_q : wr_row;
  assign copy_valid = (state_q == ST_COPY);
  assign copy_src   = row_ptr;
  assign copy_dst   = dst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q      <= '0;
      ep_q       <= '0;
      dst_q      <= '0;
      prev_q     <= '0;
      has_prev_q <= 1'b0;
    end else if (load) begin
      row_q      <= wr_row;
      ep_q       <= wr_epoch;
      dst_q      <= alloc_ptr;
      prev_q     <= main_tag;
      has_prev_q <= ever;
    end
  end

  assert_copy_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_valid && !copy_done) |=> (copy_valid && $stable(copy_dst) && $stable(copy_src)));

  assert_dst_in_log_R2: assert property (@(posedge clk) disable iff (!rst_n)
    copy_valid |-> (copy_dst >= LOG_BASE));

  assert_main_tag_points_log_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_we && tag_addr < LOG_BASE) |-> (tag_data >= LOG_BASE));

  assert_no_copy_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    log_full |-> !copy_valid);

  assert_fwd_after_tags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && fwd_row == row_q && $past(tag_we)) |-> !copy_valid && !tag_we);

  assert_hit_no_side_effect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && !$past(tag_we)) |-> (!tag_we && !copy_valid));
endmodule

// File: tb/tb_row_cow_logger.sv
module tb_row_cow_logger;
  localparam int MAIN = 16;
  localparam int LOGN = 8;
  localparam int NL   = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_valid, copy_done;
  logic [3:0] wr_row, wr_epoch;
  logic       wr_ready, fwd_valid, copy_valid, tag_we, log_full;
  logic [3:0] fwd_row;
  logic [4:0] copy_src, copy_dst, tag_addr, tag_data;
  logic [1:0] lst_rd_sel;
  logic [2:0] lst_rd_slot;
  logic [3:0] lst_rd_epoch, lst_rd_row;
  logic [3:0] lst_rd_count;

  always #2 clk = ~clk;

  row_cow_logger dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_row(wr_row), .wr_epoch(wr_epoch),
    .wr_ready(wr_ready), .fwd_valid(fwd_valid), .fwd_row(fwd_row),
    .copy_valid(copy_valid), .copy_src(copy_src), .copy_dst(copy_dst), .copy_done(copy_done),
    .tag_we(tag_we), .tag_addr(tag_addr), .tag_data(tag_data), .log_full(log_full),
    .lst_rd_sel(lst_rd_sel), .lst_rd_slot(lst_rd_slot), .lst_rd_epoch(lst_rd_epoch),
    .lst_rd_count(lst_rd_count), .lst_rd_row(lst_rd_row)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit ended = 0;

  // behavioural reference state
  int  m_ep   [MAIN];
  bit  m_seen [MAIN];
  int  m_new  [MAIN];
  int  m_used;
  bit  l_live [NL];
  int  l_ep   [NL];
  int  l_cnt  [NL];
  int  l_ent  [NL][LOGN];

  task automatic chk(string req, string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect_cyc(string req, bit rdy, int frow, bit cv, int cdst, int csrc,
                            bit twe, int ta, int td);
    chk(req, "wr_ready", int'(wr_ready), int'(rdy));
    chk(req, "fwd_valid", int'(fwd_valid), int'(rdy));
    if (rdy) chk(req, "fwd_row", int'(fwd_row), frow);
    chk(req, "copy_valid", int'(copy_valid), int'(cv));
    if (cv) begin
      chk(req, "copy_dst", int'(copy_dst), cdst);
      chk(req, "copy_src", int'(copy_src), csrc);
    end
    chk(req, "tag_we", int'(tag_we), int'(twe));
    if (twe) begin
      chk(req, "tag_addr", int'(tag_addr), ta);
      chk(req, "tag_data", int'(tag_data), td);
    end
    chk("R7", "log_full", int'(log_full), int'(m_used == LOGN));
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  // One eviction write; lat = extra cycles before copy acknowledge,
  // ep_hold = epoch value driven while the write is held (R9).
  task automatic write_txn(string req, int row, int ep, int lat, int ep_hold);
    bit hit;
    int dst, sel, slot;
    @(negedge clk);
    wr_valid = 1'b1; wr_row = row[3:0]; wr_epoch = ep[3:0]; copy_done = 1'b0;
    #1;
    hit = m_seen[row] && (m_ep[row] == ep);
    if (hit) begin
      expect_cyc(req, 1'b1, row, 1'b0, 0, 0, 1'b0, 0, 0);
      @(negedge clk); wr_valid = 1'b0;
      return;
    end
    if (m_used == LOGN) begin
      for (int k = 0; k < 3; k++) begin
        expect_cyc(req, 1'b0, 0, 1'b0, 0, 0, 1'b0, 0, 0);
        step();
      end
      wr_valid = 1'b0;
      return;
    end
    expect_cyc(req, 1'b0, 0, 1'b0, 0, 0, 1'b0, 0, 0);
    dst = MAIN + m_used;
    for (int k = 0; k <= lat; k++) begin
      @(negedge clk);
      wr_epoch  = ep_hold[3:0];
      copy_done = (k == lat);
      #1;
      expect_cyc("R4", 1'b0, 0, 1'b1, dst, row, 1'b0, 0, 0);
    end
    @(negedge clk); copy_done = 1'b0; #1;
    expect_cyc("R5", 1'b0, 0, 1'b0, 0, 0, 1'b1, row, dst);
    step();
    expect_cyc("R5", 1'b0, 0, 1'b0, 0, 0, 1'b1, dst, row);
    if (m_seen[row]) begin
      step();
      expect_cyc("R5", 1'b0, 0, 1'b0, 0, 0, 1'b1, m_new[row], dst);
    end
    step();
    expect_cyc("R6", 1'b1, row, 1'b0, 0, 0, 1'b0, 0, 0);
    // reference update
    sel = ep % NL;
    if (l_live[sel] && l_ep[sel] == ep) slot = l_cnt[sel];
    else begin slot = 0; l_live[sel] = 1; l_ep[sel] = ep; end
    l_cnt[sel] = slot + 1;
    l_ent[sel][slot] = row;
    m_seen[row] = 1; m_ep[row] = ep; m_new[row] = dst; m_used++;
    @(negedge clk);
    wr_valid = 1'b0;
    lst_rd_sel = sel[1:0]; lst_rd_slot = slot[2:0];
    #1;
    expect_cyc("R6", 1'b0, 0, 1'b0, 0, 0, 1'b0, 0, 0);
    chk("R6", "list_count", int'(lst_rd_count), l_cnt[sel]);
    chk("R9", "list_epoch", int'(lst_rd_epoch), ep);
    chk("R6", "list_row", int'(lst_rd_row), row);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    for (int i = 0; i < MAIN; i++) begin m_ep[i] = 0; m_seen[i] = 0; m_new[i] = 0; end
    for (int i = 0; i < NL; i++) begin l_live[i] = 0; l_ep[i] = 0; l_cnt[i] = 0; end
    m_used = 0;
    rst_n = 1'b0; wr_valid = 1'b0; wr_row = '0; wr_epoch = '0; copy_done = 1'b0;
    lst_rd_sel = '0; lst_rd_slot = '0;
    repeat (3) @(negedge clk);
    #1;
    expect_cyc("R1", 1'b0, 0, 1'b0, 0, 0, 1'b0, 0, 0);
    @(negedge clk); rst_n = 1'b1;
    for (int s = 0; s < NL; s++) begin
      @(negedge clk); lst_rd_sel = s[1:0]; #1;
      expect_cyc("R1", 1'b0, 0, 1'b0, 0, 0, 1'b0, 0, 0);
      chk("R1", "list_count", int'(lst_rd_count), 0);
    end

    write_txn("R4", 3, 1, 0, 1);    // first entry, no older version
    write_txn("R3", 3, 1, 0, 1);    // already saved this epoch
    write_txn("R2", 5, 1, 2, 1);    // second log row, slow ack
    write_txn("R8", 3, 2, 1, 2);    // new epoch -> chain with older entry
    write_txn("R9", 7, 2, 1, 9);    // epoch input moves while held
    write_txn("R6", 3, 5, 0, 5);    // list 1 reused by epoch 5 -> slot 0
    write_txn("R5", 9, 5, 0, 5);
    write_txn("R3", 9, 5, 0, 5);
    write_txn("R6", 10, 5, 3, 5);
    write_txn("R2", 11, 5, 0, 5);   // last free log row
    write_txn("R7", 12, 5, 0, 5);   // full: held, no copy
    write_txn("R7", 11, 5, 0, 5);   // full: hit still forwarded
    write_txn("R7", 3, 6, 0, 6);    // full: epoch change needs a copy -> held
    repeat (3) begin
      step();
      expect_cyc("R1", 1'b0, 0, 1'b0, 0, 0, 1'b0, 0, 0);
    end
    finish_run();
  end
endmodule